// File: doc/BRIEF.md
# Iterative Integer Divider

A sequential divide unit for a 16-bit datapath. It divides a 32-bit or a 16-bit dividend by a 16-bit divisor and returns a 16-bit quotient and a 16-bit remainder. Two mode inputs choose the operand size and whether the operands are two's-complement signed or unsigned. The four modes are 32/16 signed, 32/16 unsigned, 16/16 signed and 16/16 unsigned. All four run on one shared restoring engine.

The engine always makes one iteration per divisor bit. Every mode therefore takes the same number of cycles, whatever the dividend size. A one-cycle start pulse captures the operands and the mode. Busy stays high while the work is in progress. Done pulses once when the quotient, the remainder and the two status flags (divide-by-zero and overflow) are valid. These results stay in output registers until the next operation completes.

Signed operation divides magnitudes and then applies the signs in one final cycle. The quotient is truncated toward zero.

Top module: `int_divider`

## Requirements
- R1: With `is_long`=1 the dividend is the 32-bit value {`dvd_hi`,`dvd_lo`}; `is_signed`=1 treats dividend and divisor as two's complement, 0 as unsigned; a valid result gives `quotient` = dividend / divisor and `remainder` = dividend − quotient·divisor, each as its low 16 bits.
- R2: With `is_long`=0 the dividend is `dvd_lo` sign-extended (signed) or zero-extended (unsigned) to 32 bits, and `dvd_hi` has no effect on any output.
- R3: Signed division truncates toward zero; a nonzero remainder has the sign of the dividend and a magnitude below that of the divisor.
- R4: `start` is taken only while `busy` is low. `busy` is high in the 17 cycles after the edge that takes `start`. `done` is high for exactly one cycle, following the 17th edge after the one that took `start`. This timing is the same in all four modes.
- R5: A `start` seen while `busy` is high is ignored: the operands and mode already captured, the timing and the result are unchanged.
- R6: A zero divisor gives `div_zero`=1, `overflow`=0, `quotient`=16'hFFFF and `remainder`=`dvd_lo` as captured at start.
- R7: When the divisor is nonzero and the true quotient is outside −32768..32767 (signed) or 0..65535 (unsigned), the result is `overflow`=1, `div_zero`=0, `quotient`=16'hFFFF and `remainder`=`dvd_lo` as captured at start.
- R8: After reset `busy`, `done`, `quotient`, `remainder`, `div_zero` and `overflow` are all 0. The result outputs and flags change only in the cycle where `done` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| start | input | 1 | One-cycle request to begin a divide |
| is_long | input | 1 | 1: 32-bit dividend, 0: 16-bit dividend |
| is_signed | input | 1 | 1: signed operands, 0: unsigned |
| dvd_hi | input | 16 | Upper dividend word (long mode only) |
| dvd_lo | input | 16 | Lower dividend word |
| dvs | input | 16 | Divisor |
| busy | output | 1 | Divide in progress |
| done | output | 1 | One-cycle result-valid pulse |
| quotient | output | 16 | Quotient result register |
| remainder | output | 16 | Remainder result register |
| div_zero | output | 1 | Divisor was zero |
| overflow | output | 1 | Quotient did not fit the selected range |

## Verification
The assertions assume that operands matter only in the cycle that `start` is taken. Outside that cycle they may hold any value, including while `busy` is high. The assertions also assume that `start` may arrive at any time, including during the final correction cycle. The bench drives all inputs on the falling edge. It changes the operands and raises stray `start` pulses at every point of a running divide, so the ignore rule is exercised. It launches each new request in the very cycle that `done` is high, so back-to-back operation is covered.

// File: rtl/div_pkg.sv
package div_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } div_state_e;

  // Per-operation control captured at start
  typedef struct packed {
    logic neg_q;      // quotient must be negated
    logic neg_r;      // remainder must be negated (dividend negative)
    logic is_signed;  // signed range check
    logic zero;       // divisor is zero
    logic big;        // magnitude high word >= divisor: quotient >= 2^W
  } div_ctl_t;

endpackage

// File: rtl/div_rst_sync.sv
module div_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_sync_n = hold_q;

endmodule

// File: rtl/div_prep.sv
module div_prep
  import div_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         is_long,
  input  logic         is_signed,
  input  logic [W-1:0] dvd_hi,
  input  logic [W-1:0] dvd_lo,
  input  logic [W-1:0] dvs,
  output logic [W-1:0] mag_hi,
  output logic [W-1:0] mag_lo,
  output logic [W-1:0] mag_d,
  output div_ctl_t     ctl
);

  localparam int DW = 2 * W;

  logic [DW-1:0] ext_n;
  logic [DW-1:0] mag_n;
  logic          neg_n;
  logic          neg_d;

  always_comb begin
    if (is_long) begin
      ext_n = {dvd_hi, dvd_lo};
    end else if (is_signed) begin
      ext_n = {{W{dvd_lo[W-1]}}, dvd_lo};
    end else begin
      ext_n = {{W{1'b0}}, dvd_lo};
    end
    neg_n  = is_signed & ext_n[DW-1];
    neg_d  = is_signed & dvs[W-1];
    mag_n  = neg_n ? (~ext_n + 1'b1) : ext_n;
    mag_d  = neg_d ? (~dvs + 1'b1) : dvs;
    mag_hi = mag_n[DW-1:W];
    mag_lo = mag_n[W-1:0];
    ctl.neg_q     = neg_n ^ neg_d;
    ctl.neg_r     = neg_n;
    ctl.is_signed = is_signed;
    ctl.zero      = (dvs == '0);
    ctl.big       = (mag_hi >= mag_d);
  end

endmodule

// File: rtl/div_core.sv
module div_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] hi_i,
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] dvs_i,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o
);

  logic [W-1:0] part_q, part_d;
  logic [W-1:0] shf_q, shf_d;
  logic [W-1:0] dvs_q, dvs_d;
  logic [W:0]   trial;
  logic [W+1:0] diff;
  logic         fits;
  logic         en;

  always_comb begin
    trial  = {part_q, shf_q[W-1]};
    diff   = {1'b0, trial} - {2'b00, dvs_q};
    fits   = ~diff[W+1];
    part_d = part_q;
    shf_d  = shf_q;
    dvs_d  = dvs_q;
    if (load) begin
      part_d = hi_i;
      shf_d  = lo_i;
      dvs_d  = dvs_i;
    end else if (step) begin
      part_d = fits ? diff[W-1:0] : trial[W-1:0];
      shf_d  = {shf_q[W-2:0], fits};
    end
  end

  assign en = load | step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      part_q <= '0;
      shf_q  <= '0;
      dvs_q  <= '0;
    end else if (en) begin
      part_q <= part_d;
      shf_q  <= shf_d;
      dvs_q  <= dvs_d;
    end
  end

  assign quo_o = shf_q;
  assign rem_o = part_q;

  // Partial remainder stays below the divisor once it starts there
  AST_PARTIAL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (step && (part_q < dvs_q)) |=> (part_q < dvs_q)); // R3

  AST_LOAD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (load && (hi_i < dvs_i)) |=> (part_q < dvs_q)); // R1

endmodule

// File: rtl/div_post.sv
module div_post
  import div_pkg::*;
#(
  parameter int W = 16
) (
  input  div_ctl_t     ctl,
  input  logic [W-1:0] mag_q,
  input  logic [W-1:0] mag_r,
  input  logic [W-1:0] raw_lo,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem,
  output logic         zero,
  output logic         ovf
);

  localparam logic [W-1:0] HALF = {1'b1, {(W-1){1'b0}}};

  logic         range_bad;
  logic         err;
  logic [W-1:0] sq;
  logic [W-1:0] sr;

  always_comb begin
    sq = ctl.neg_q ? (~mag_q + 1'b1) : mag_q;
    sr = ctl.neg_r ? (~mag_r + 1'b1) : mag_r;
    if (ctl.is_signed) begin
      range_bad = ctl.neg_q ? (mag_q > HALF) : mag_q[W-1];
    end else begin
      range_bad = 1'b0;
    end
    zero = ctl.zero;
    ovf  = ~ctl.zero & (ctl.big | range_bad);
    err  = zero | ovf;
    quo  = err ? '1 : sq;
    rem  = err ? raw_lo : sr;
  end

endmodule

// File: rtl/int_divider.sv
module int_divider
  import div_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         is_long,
  input  logic         is_signed,
  input  logic [W-1:0] dvd_hi,
  input  logic [W-1:0] dvd_lo,
  input  logic [W-1:0] dvs,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic         div_zero,
  output logic         overflow
);

  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic         rst_sync_n;
  div_state_e   state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  div_ctl_t     ctl_q, ctl_in;
  logic [W-1:0] lo_q;
  logic [W-1:0] mag_hi, mag_lo, mag_d;
  logic [W-1:0] core_q, core_r;
  logic [W-1:0] post_q, post_r;
  logic         post_z, post_o;
  logic         take;
  logic         step;
  logic         fin;

  div_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  div_prep #(.W(W)) u_prep (
    .is_long   (is_long),
    .is_signed (is_signed),
    .dvd_hi    (dvd_hi),
    .dvd_lo    (dvd_lo),
    .dvs       (dvs),
    .mag_hi    (mag_hi),
    .mag_lo    (mag_lo),
    .mag_d     (mag_d),
    .ctl       (ctl_in)
  );

  div_core #(.W(W)) u_core (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .load  (take),
    .step  (step),
    .hi_i  (mag_hi),
    .lo_i  (mag_lo),
    .dvs_i (mag_d),
    .quo_o (core_q),
    .rem_o (core_r)
  );

  div_post #(.W(W)) u_post (
    .ctl    (ctl_q),
    .mag_q  (core_q),
    .mag_r  (core_r),
    .raw_lo (lo_q),
    .quo    (post_q),
    .rem    (post_r),
    .zero   (post_z),
    .ovf    (post_o)
  );

  assign take = start & (state_q == ST_IDLE);
  assign step = (state_q == ST_RUN);
  assign fin  = (state_q == ST_FIN);

  // Next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (take) begin
          state_d = ST_RUN;
          cnt_d   = '0;
        end
      end
      ST_RUN: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          state_d = ST_FIN;
        end
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done    <= fin;
    end
  end

  // Operation capture, enabled by an accepted start
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ctl_q <= '0;
      lo_q  <= '0;
    end else if (take) begin
      ctl_q <= ctl_in;
      lo_q  <= dvd_lo;
    end
  end

  // Result registers, enabled in the correction cycle
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      quotient  <= '0;
      remainder <= '0;
      div_zero  <= 1'b0;
      overflow  <= 1'b0;
    end else if (fin) begin
      quotient  <= post_q;
      remainder <= post_r;
      div_zero  <= post_z;
      overflow  <= post_o;
    end
  end

  assign busy = (state_q != ST_IDLE);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |=> !done); // R4

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |-> (!busy && $past(busy))); // R4

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (busy && start) |=> ($stable(ctl_q) && $stable(lo_q))); // R5

  AST_ZERO_RESULT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done && div_zero) |-> ((quotient == '1) && !overflow && (remainder == lo_q))); // R6

  AST_OVF_RESULT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done && overflow) |-> ((quotient == '1) && !div_zero)); // R7

  AST_REM_SIGN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done && ctl_q.is_signed && !div_zero && !overflow && (remainder != '0))
      |-> (remainder[W-1] == ctl_q.neg_r)); // R3

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !fin |=> ($stable(quotient) && $stable(remainder))); // R8

endmodule

// File: tb/int_divider_tb_top.sv
module int_divider_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 17;
  localparam int WDOG       = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        is_long = 1'b0;
  logic        is_signed = 1'b0;
  logic [15:0] dvd_hi = '0;
  logic [15:0] dvd_lo = '0;
  logic [15:0] dvs = '0;
  logic        busy, done, div_zero, overflow;
  logic [15:0] quotient, remainder;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit chk_on = 1'b0;
  bit r5_mark = 1'b0;

  // Reference model state
  int          m_cnt = 0;
  bit          m_done = 1'b0;
  logic [15:0] m_q = '0, m_r = '0;
  bit          m_z = 1'b0, m_o = 1'b0;
  logic [15:0] p_q = '0, p_r = '0;
  bit          p_z = 1'b0, p_o = 1'b0;
  string       p_tag = "R1";
  string       m_tag = "R1";

  int_divider dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .is_long   (is_long),
    .is_signed (is_signed),
    .dvd_hi    (dvd_hi),
    .dvd_lo    (dvd_lo),
    .dvs       (dvs),
    .busy      (busy),
    .done      (done),
    .quotient  (quotient),
    .remainder (remainder),
    .div_zero  (div_zero),
    .overflow  (overflow)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic ref_div(input bit lg, input bit sg,
                         input logic [15:0] hi, input logic [15:0] lo, input logic [15:0] d,
                         output logic [15:0] q, output logic [15:0] r,
                         output bit z, output bit o);
    longint n, dv, qq, rr;
    if (lg) n = sg ? longint'($signed({hi, lo})) : longint'({hi, lo});
    else    n = sg ? longint'($signed(lo)) : longint'(lo);
    dv = sg ? longint'($signed(d)) : longint'(d);
    z = (dv == 0);
    o = 1'b0;
    if (z) begin
      q = 16'hFFFF;
      r = lo;
    end else begin
      qq = n / dv;
      rr = n % dv;
      if (sg) o = (qq > 32767) || (qq < -32768);
      else    o = (qq > 65535);
      if (o) begin
        q = 16'hFFFF;
        r = lo;
      end else begin
        q = qq[15:0];
        r = rr[15:0];
      end
    end
  endtask

  // Cycle-level model: latency counter plus pending result
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_done = 1'b0;
      m_q = '0; m_r = '0; m_z = 1'b0; m_o = 1'b0;
    end else begin
      m_done = 1'b0;
      if (m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_done = 1'b1;
          m_q = p_q; m_r = p_r; m_z = p_z; m_o = p_o;
          m_tag = p_tag;
        end
      end else if (start) begin
        ref_div(is_long, is_signed, dvd_hi, dvd_lo, dvs, p_q, p_r, p_z, p_o);
        m_cnt = LAT;
        if (p_z)           p_tag = "R6";
        else if (p_o)      p_tag = "R7";
        else if (!is_long) p_tag = "R2";
        else if (is_signed) p_tag = "R3";
        else               p_tag = "R1";
        if (r5_mark) p_tag = {p_tag, "/R5"};
      end
    end
  end

  // Compare on every falling edge
  always @(negedge clk) begin
    if (chk_on) begin
      string t;
      t = m_done ? m_tag : "R8";
      chk("R4", "busy", {31'd0, busy}, {31'd0, (m_cnt > 0)});
      chk("R4", "done", {31'd0, done}, {31'd0, m_done});
      chk(t, "quotient",  {16'd0, quotient},  {16'd0, m_q});
      chk(t, "remainder", {16'd0, remainder}, {16'd0, m_r});
      chk(t, "div_zero",  {31'd0, div_zero},  {31'd0, m_z});
      chk(t, "overflow",  {31'd0, overflow},  {31'd0, m_o});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG) begin
      bad++;
      total++;
      $display("FAIL R4 watchdog actual=%0d expected<=%0d", cyc, WDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // Issue one divide; optionally inject a stray start while busy (R5)
  task automatic run_op(input bit lg, input bit sg, input logic [15:0] hi,
                        input logic [15:0] lo, input logic [15:0] d, input bit inject);
    while (busy) @(negedge clk);
    r5_mark   = inject;
    is_long   = lg;
    is_signed = sg;
    dvd_hi    = hi;
    dvd_lo    = lo;
    dvs       = d;
    start     = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (inject) begin
      int j;
      j = 1 + int'($urandom % 16);
      repeat (j) @(negedge clk);
      is_long   = ~lg;
      is_signed = ~sg;
      dvd_hi    = 16'($urandom);
      dvd_lo    = 16'($urandom);
      dvs       = 16'($urandom);
      start     = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk_on = 1'b1;
    // R8: reset state seen at the ports
    chk("R8", "reset busy/done", {30'd0, busy, done}, 32'd0);
    chk("R8", "reset results", {quotient, remainder}, 32'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    for (int m = 0; m < 4; m++) begin
      bit lg, sg;
      lg = m[1];
      sg = m[0];
      // Corner cases: divisor 1, all-ones (-1 / 65535), zero dividend,
      // most-negative dividend, zero divisor, most-negative divisor
      run_op(lg, sg, 16'h0000, 16'h1234, 16'h0001, 1'b0);
      run_op(lg, sg, 16'hFFFF, 16'hFFFF, 16'hFFFF, 1'b0);
      run_op(lg, sg, 16'h0000, 16'h0000, 16'h0007, 1'b0);
      run_op(lg, sg, 16'h0000, 16'h0000, 16'h0000, 1'b0);
      run_op(lg, sg, 16'h8000, 16'h0000, 16'hFFFF, 1'b0);
      run_op(lg, sg, 16'hFFFF, 16'h8000, 16'hFFFF, 1'b0);
      run_op(lg, sg, 16'hFFFF, 16'h8000, 16'h0001, 1'b0);
      run_op(lg, sg, 16'h8000, 16'h0000, 16'h8000, 1'b0);
      run_op(lg, sg, 16'h4000, 16'h0000, 16'h8000, 1'b0);
      run_op(lg, sg, 16'h7FFF, 16'hFFFF, 16'h0000, 1'b0);
      run_op(lg, sg, 16'hC000, 16'h0001, 16'h7FFF, 1'b0);
      run_op(lg, sg, 16'hFFFF, 16'hFFF9, 16'h0002, 1'b0);
      run_op(lg, sg, 16'h0000, 16'h0007, 16'hFFFE, 1'b0);
      for (int k = 0; k < 60; k++) begin
        logic [15:0] d, hi, lo;
        d  = 16'($urandom);
        lo = 16'($urandom);
        case (k % 3)
          0: hi = 16'($urandom);
          1: hi = (d == 0) ? 16'h0 : 16'($urandom % {16'h0, d});
          default: hi = {16{lo[15]}} & 16'($urandom % 4);
        endcase
        if (k % 5 == 0) d = 16'($urandom % 8);
        run_op(lg, sg, hi, lo, d, (k % 4) == 1);
      end
    end

    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule